// File: doc/BRIEF.md
# Dual-Threshold Receiver AGC Controller

This block closes the digital side of a receiver gain loop. A power estimator outside the block delivers one signal level per sample on `lvl_in`. The level is a signed number of 1/64 dB steps relative to full scale. The block decides when the front-end gain must change and by how much. It keeps the accumulated gain command and presents each change on `gain_out`, together with a one-cycle `gain_valid` strobe and a `gain_src` code naming the loop that caused it. The attenuator and any dB-to-linear mapping sit downstream.

Three loops share the decision, and at most one of them acts on any sample. An overload check cuts gain at once by a programmable step when a sample is above the upper threshold. A deep-fade loop takes over when a sample drops below the lower threshold. It gathers the peak level over a programmable number of samples and raises gain by a small step at the end of each window whose peak stayed low. It hands control back when a window's peak recovers. The rest of the time a slow loop averages the error against a requested level over a power-of-two window. It ignores average errors inside a hysteresis band and otherwise applies the average error scaled down by a power-of-two loop gain.

All thresholds, steps, window lengths and gain limits are written through a small write-only register port. A 2-flop synchronizer releases the asynchronous reset.

Top module: `agc_ctrl`

## Requirements
- R1: After reset `gain_out` is 0, `gain_valid` is 0 and `gain_src` is 0 until the first decision.
- R2: A sample with `lvl_in` strictly above the upper threshold lowers the gain by the upper step, with `gain_src` = 1. It also empties both the fade window and the slow integrator and leaves fast mode.
- R3: A sample strictly below the lower threshold starts fast mode and suspends the slow loop. After every `fast_len` samples in fast mode (0 counts as 1) whose peak stays below the lower threshold, gain rises by the fast step with `gain_src` = 2.
- R4: When a fast-mode window ends with its peak at or above the lower threshold, the gain is left unchanged, no strobe is given and fast mode ends.
- R5: Outside fast mode, the slow loop sums (target − level) over 2^`slow_log2` samples. At the end of the window it takes mean = sum >>> `slow_log2` (arithmetic) and clears the sum. If the mean lies outside the band, gain changes by mean >>> `gain_shift`, with `gain_src` = 3.
- R6: A slow-loop mean with |mean| ≤ `hyst` produces no strobe and no gain change.
- R7: At most one loop updates per sample, with priority overload, then fast, then slow. `gain_src` is 0 whenever `gain_valid` is low.
- R8: The new gain is the sum of old gain and step, clamped to [`gain_min`, `gain_max`].
- R9: Register addresses and reset values are: 0 upper threshold (−384), 1 upper step (64), 2 lower threshold (−2560), 3 fast step (6), 4 fast_len (4, 8 bits), 5 target (−1280), 6 hyst (128), 7 slow_log2 (4, 3 bits), 8 gain_shift (2, 4 bits), 9 gain_min (−2048), 10 gain_max (2048). Writes to addresses 11..15 have no effect.
- R10: `gain_valid` pulses one cycle after the deciding sample's clock edge. With no sample there is no strobe, and `gain_out` holds whenever `gain_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 16 | Register write data |
| lvl_valid | input | 1 | A level sample is present |
| lvl_in | input | 16 | Signed level, 1/64 dB per LSB |
| gain_valid | output | 1 | One-cycle strobe for a gain update |
| gain_out | output | 16 | Signed accumulated gain, 1/64 dB per LSB |
| gain_src | output | 2 | Loop that made the update: 1 overload, 2 fast, 3 slow |

## Verification
Directed runs start from the reset values. Levels far below the lower threshold show the fast window counting and stepping. A single loud sample separates the overload path from both averaging loops. A fade window that ends on a recovered level shows fast mode releasing without a strobe. Slow windows held exactly on target and exactly one band-width off confirm the hysteresis boundary, and one just outside it gives a scaled step. Tight gain limits drive the clamp at both ends. A long seeded random mix of loud, faded and near-target levels, idle gaps and register rewrites checks how the loops hand over to each other and the priority order.

// File: rtl/agc_pkg.sv
package agc_pkg;
  localparam int DW      = 16;
  localparam int AW      = 4;
  localparam int FAST_W  = 8;
  localparam int LOG2_W  = 3;
  localparam int SHIFT_W = 4;
  localparam int ERR_W   = DW + 1;
  localparam int CNT_W   = 2 ** LOG2_W;
  localparam int ACC_W   = ERR_W + CNT_W - 1;
  localparam int SUM_W   = ACC_W + 1;

  typedef logic signed [DW-1:0] lvl_t;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_OVL  = 2'd1,
    SRC_FADE = 2'd2,
    SRC_SLOW = 2'd3
  } agc_src_e;

  typedef struct packed {
    lvl_t                upper_thr;
    logic [DW-1:0]       upper_step;
    lvl_t                lower_thr;
    logic [DW-1:0]       fast_step;
    logic [FAST_W-1:0]   fast_len;
    lvl_t                target;
    logic [DW-1:0]       hyst;
    logic [LOG2_W-1:0]   slow_log2;
    logic [SHIFT_W-1:0]  gain_shift;
    lvl_t                gain_min;
    lvl_t                gain_max;
  } agc_cfg_t;

  localparam logic [AW-1:0] ADR_UPPER_THR  = 4'd0;
  localparam logic [AW-1:0] ADR_UPPER_STEP = 4'd1;
  localparam logic [AW-1:0] ADR_LOWER_THR  = 4'd2;
  localparam logic [AW-1:0] ADR_FAST_STEP  = 4'd3;
  localparam logic [AW-1:0] ADR_FAST_LEN   = 4'd4;
  localparam logic [AW-1:0] ADR_TARGET     = 4'd5;
  localparam logic [AW-1:0] ADR_HYST       = 4'd6;
  localparam logic [AW-1:0] ADR_SLOW_LOG2  = 4'd7;
  localparam logic [AW-1:0] ADR_SHIFT      = 4'd8;
  localparam logic [AW-1:0] ADR_GAIN_MIN   = 4'd9;
  localparam logic [AW-1:0] ADR_GAIN_MAX   = 4'd10;

  localparam agc_cfg_t CFG_RST = '{
    upper_thr:  -16'sd384,
    upper_step: 16'd64,
    lower_thr:  -16'sd2560,
    fast_step:  16'd6,
    fast_len:   8'd4,
    target:     -16'sd1280,
    hyst:       16'd128,
    slow_log2:  3'd4,
    gain_shift: 4'd2,
    gain_min:   -16'sd2048,
    gain_max:   16'sd2048
  };
endpackage

// File: rtl/agc_cfg_regs.sv
module agc_cfg_regs
  import agc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [AW-1:0]       addr,
  input  logic [DW-1:0]       wdata,
  output agc_cfg_t            cfg
);
  agc_cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (we) begin
      case (addr)
        ADR_UPPER_THR:  cfg_d.upper_thr  = wdata;
        ADR_UPPER_STEP: cfg_d.upper_step = wdata;
        ADR_LOWER_THR:  cfg_d.lower_thr  = wdata;
        ADR_FAST_STEP:  cfg_d.fast_step  = wdata;
        ADR_FAST_LEN:   cfg_d.fast_len   = wdata[FAST_W-1:0];
        ADR_TARGET:     cfg_d.target     = wdata;
        ADR_HYST:       cfg_d.hyst       = wdata;
        ADR_SLOW_LOG2:  cfg_d.slow_log2  = wdata[LOG2_W-1:0];
        ADR_SHIFT:      cfg_d.gain_shift = wdata[SHIFT_W-1:0];
        ADR_GAIN_MIN:   cfg_d.gain_min   = wdata;
        ADR_GAIN_MAX:   cfg_d.gain_max   = wdata;
        default:        cfg_d = cfg_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= CFG_RST;
    else if (we) cfg_q <= cfg_d;
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/agc_fast_loop.sv
module agc_fast_loop
  import agc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_en,
  input  logic              ovl,
  input  lvl_t              level,
  input  lvl_t              lower_thr,
  input  logic [FAST_W-1:0] fast_len,
  output logic              engaged,
  output logic              fire
);
  logic              fade_q, fade_d;
  logic [FAST_W-1:0] cnt_q, cnt_d;
  lvl_t              peak_q, peak_d;
  lvl_t              peak_n;
  logic [FAST_W-1:0] len_eff, cnt_inc;
  logic              below, win_end, en;

  always_comb begin
    below   = level < lower_thr;
    engaged = !ovl && (fade_q || below);
    len_eff = (fast_len == '0) ? FAST_W'(1) : fast_len;
    cnt_inc = cnt_q + FAST_W'(1);
    win_end = cnt_inc >= len_eff;
    if (cnt_q == '0) peak_n = level;
    else             peak_n = (level > peak_q) ? level : peak_q;

    fade_d = fade_q;
    cnt_d  = cnt_q;
    peak_d = peak_q;
    fire   = 1'b0;
    if (ovl) begin
      fade_d = 1'b0;
      cnt_d  = '0;
    end else if (engaged) begin
      fade_d = 1'b1;
      peak_d = peak_n;
      if (win_end) begin
        cnt_d = '0;
        if (peak_n < lower_thr) fire = smp_en;
        else                    fade_d = 1'b0;
      end else begin
        cnt_d = cnt_inc;
      end
    end
  end

  assign en = smp_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fade_q <= 1'b0;
      cnt_q  <= '0;
      peak_q <= '0;
    end else if (en) begin
      fade_q <= fade_d;
      cnt_q  <= cnt_d;
      peak_q <= peak_d;
    end
  end
endmodule

// File: rtl/agc_slow_loop.sv
module agc_slow_loop
  import agc_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_en,
  input  logic                     hold,
  input  lvl_t                     level,
  input  lvl_t                     target,
  input  logic [DW-1:0]            hyst,
  input  logic [LOG2_W-1:0]        slow_log2,
  input  logic [SHIFT_W-1:0]       gain_shift,
  output logic                     fire,
  output logic signed [ACC_W-1:0]  step
);
  logic signed [ACC_W-1:0] acc_q, acc_d, acc_sum, mean, hyst_ext, hyst_neg;
  logic signed [ERR_W-1:0] err;
  logic [CNT_W-1:0]        cnt_q, cnt_d, cnt_inc, period;
  logic                    win_end, outside;

  always_comb begin
    err      = {target[DW-1], target} - {level[DW-1], level};
    acc_sum  = acc_q + {{(ACC_W-ERR_W){err[ERR_W-1]}}, err};
    cnt_inc  = cnt_q + CNT_W'(1);
    period   = CNT_W'(1) << slow_log2;
    win_end  = cnt_inc >= period;
    mean     = acc_sum >>> slow_log2;
    hyst_ext = {{(ACC_W-DW){1'b0}}, hyst};
    hyst_neg = -hyst_ext;
    outside  = (mean > hyst_ext) || (mean < hyst_neg);
    step     = mean >>> gain_shift;

    acc_d = acc_q;
    cnt_d = cnt_q;
    fire  = 1'b0;
    if (hold) begin
      acc_d = '0;
      cnt_d = '0;
    end else if (win_end) begin
      acc_d = '0;
      cnt_d = '0;
      fire  = smp_en && outside;
    end else begin
      acc_d = acc_sum;
      cnt_d = cnt_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (smp_en) begin
      acc_q <= acc_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/agc_gain_accum.sv
module agc_gain_accum
  import agc_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    upd,
  input  logic signed [ACC_W-1:0] step,
  input  agc_src_e                src,
  input  lvl_t                    gain_min,
  input  lvl_t                    gain_max,
  output lvl_t                    gain,
  output logic                    valid,
  output agc_src_e                src_out
);
  lvl_t                    gain_q, gain_d;
  logic                    valid_q;
  agc_src_e                src_q, src_d;
  logic signed [SUM_W-1:0] sum, max_ext, min_ext;

  always_comb begin
    sum     = {{(SUM_W-DW){gain_q[DW-1]}}, gain_q} + {step[ACC_W-1], step};
    max_ext = {{(SUM_W-DW){gain_max[DW-1]}}, gain_max};
    min_ext = {{(SUM_W-DW){gain_min[DW-1]}}, gain_min};
    if (sum > max_ext)      gain_d = gain_max;
    else if (sum < min_ext) gain_d = gain_min;
    else                    gain_d = sum[DW-1:0];
    src_d = upd ? src : SRC_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_q  <= '0;
      valid_q <= 1'b0;
      src_q   <= SRC_NONE;
    end else begin
      valid_q <= upd;
      src_q   <= src_d;
      if (upd) gain_q <= gain_d;
    end
  end

  assign gain    = gain_q;
  assign valid   = valid_q;
  assign src_out = src_q;
endmodule

// File: rtl/agc_ctrl.sv
module agc_ctrl
  import agc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [3:0]    cfg_addr,
  input  logic [15:0]   cfg_wdata,
  input  logic          lvl_valid,
  input  logic [15:0]   lvl_in,
  output logic          gain_valid,
  output logic [15:0]   gain_out,
  output logic [1:0]    gain_src
);
  logic [1:0]              rst_sync_q;
  logic                    rst_int_n;
  agc_cfg_t                cfg;
  lvl_t                    level, upper_thr_w, lower_thr_w, gain_min_w, gain_max_w;
  logic                    ovl, fast_engaged, fast_fire, slow_fire, upd;
  logic signed [ACC_W-1:0] slow_step, step_sel;
  agc_src_e                src_sel, src_q;
  lvl_t                    gain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  agc_cfg_regs u_cfg (
    .clk   (clk),
    .rst_n (rst_int_n),
    .we    (cfg_we),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .cfg   (cfg)
  );

  assign level       = lvl_in;
  assign upper_thr_w = cfg.upper_thr;
  assign lower_thr_w = cfg.lower_thr;
  assign gain_min_w  = cfg.gain_min;
  assign gain_max_w  = cfg.gain_max;
  assign ovl         = level > upper_thr_w;

  agc_fast_loop u_fast (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .smp_en    (lvl_valid),
    .ovl       (ovl),
    .level     (level),
    .lower_thr (lower_thr_w),
    .fast_len  (cfg.fast_len),
    .engaged   (fast_engaged),
    .fire      (fast_fire)
  );

  agc_slow_loop u_slow (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .smp_en     (lvl_valid),
    .hold       (ovl || fast_engaged),
    .level      (level),
    .target     (cfg.target),
    .hyst       (cfg.hyst),
    .slow_log2  (cfg.slow_log2),
    .gain_shift (cfg.gain_shift),
    .fire       (slow_fire),
    .step       (slow_step)
  );

  always_comb begin
    step_sel = '0;
    src_sel  = SRC_NONE;
    if (ovl) begin
      step_sel = -$signed({{(ACC_W-DW){1'b0}}, cfg.upper_step});
      src_sel  = SRC_OVL;
    end else if (fast_fire) begin
      step_sel = $signed({{(ACC_W-DW){1'b0}}, cfg.fast_step});
      src_sel  = SRC_FADE;
    end else if (slow_fire) begin
      step_sel = slow_step;
      src_sel  = SRC_SLOW;
    end
    upd = lvl_valid && (src_sel != SRC_NONE);
  end

  agc_gain_accum u_gain (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .upd      (upd),
    .step     (step_sel),
    .src      (src_sel),
    .gain_min (gain_min_w),
    .gain_max (gain_max_w),
    .gain     (gain_q),
    .valid    (gain_valid),
    .src_out  (src_q)
  );

  assign gain_out = gain_q;
  assign gain_src = src_q;
endmodule

// File: rtl/agc_ctrl_chk.sv
module agc_ctrl_chk (
  input logic               clk,
  input logic               rst_n,
  input logic               lvl_valid,
  input logic signed [15:0] lvl_in,
  input logic               gain_valid,
  input logic signed [15:0] gain_out,
  input logic [1:0]         gain_src,
  input logic signed [15:0] upper_thr,
  input logic signed [15:0] lower_thr,
  input logic signed [15:0] gain_min,
  input logic signed [15:0] gain_max
);
  p_overload_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_valid && (lvl_in > upper_thr)) |=> (gain_valid && gain_src == 2'd1));

  p_fade_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_valid && gain_src == 2'd2) |-> ($past(lvl_in) < $past(lower_thr)));

  p_src_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !gain_valid |-> (gain_src == 2'd0));

  p_src_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    gain_valid |-> (gain_src != 2'd0));

  p_clamp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    gain_valid |-> ((gain_out <= $past(gain_max)) && (gain_out >= $past(gain_min))));

  p_no_sample_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !lvl_valid |=> !gain_valid);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !gain_valid |-> $stable(gain_out));
endmodule

bind agc_ctrl agc_ctrl_chk u_agc_ctrl_chk (
  .clk        (clk),
  .rst_n      (rst_int_n),
  .lvl_valid  (lvl_valid),
  .lvl_in     (level),
  .gain_valid (gain_valid),
  .gain_out   (gain_q),
  .gain_src   (gain_src),
  .upper_thr  (upper_thr_w),
  .lower_thr  (lower_thr_w),
  .gain_min   (gain_min_w),
  .gain_max   (gain_max_w)
);

// File: tb/test_agc_ctrl.sv
`timescale 1ns/1ps
module test_agc_ctrl;
  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_addr;
  logic [15:0] cfg_wdata;
  logic        lvl_valid;
  logic [15:0] lvl_in;
  logic        gain_valid;
  logic [15:0] gain_out;
  logic [1:0]  gain_src;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // model configuration
  int c_up, c_ustep, c_low, c_fstep, c_flen, c_tgt, c_hyst, c_log2, c_shift, c_min, c_max;
  // model state
  int m_gain, m_fcnt, m_peak, m_acc, m_scnt;
  bit m_fade;
  bit exp_valid;
  int exp_src;
  string exp_tag;

  agc_ctrl i_agc_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .lvl_valid(lvl_valid), .lvl_in(lvl_in),
    .gain_valid(gain_valid), .gain_out(gain_out), .gain_src(gain_src)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int s16(input int v);
    logic [15:0] t;
    t = v[15:0];
    return int'($signed(t));
  endfunction

  task automatic model_reset();
    c_up = -384; c_ustep = 64; c_low = -2560; c_fstep = 6; c_flen = 4;
    c_tgt = -1280; c_hyst = 128; c_log2 = 4; c_shift = 2; c_min = -2048; c_max = 2048;
    m_gain = 0; m_fcnt = 0; m_peak = 0; m_acc = 0; m_scnt = 0; m_fade = 0;
    exp_valid = 0; exp_src = 0; exp_tag = "R1";
  endtask

  task automatic apply(input int stp, input int src, input string tg);
    int s;
    s = m_gain + stp;
    exp_tag = tg;
    if (s > c_max) begin s = c_max; exp_tag = "R8"; end
    else if (s < c_min) begin s = c_min; exp_tag = "R8"; end
    m_gain = s;
    exp_valid = 1;
    exp_src = src;
  endtask

  task automatic model_sample(input int lvl);
    bit ovl, below, eng;
    int len, pk, mean;
    ovl = lvl > c_up;
    below = lvl < c_low;
    eng = !ovl && (m_fade || below);
    len = (c_flen == 0) ? 1 : c_flen;
    exp_valid = 0; exp_src = 0; exp_tag = "R7";
    if (ovl) begin
      m_fade = 0; m_fcnt = 0; m_acc = 0; m_scnt = 0;
      apply(-c_ustep, 1, "R2");
    end else if (eng) begin
      m_acc = 0; m_scnt = 0; exp_tag = "R3";
      pk = (m_fcnt == 0) ? lvl : ((lvl > m_peak) ? lvl : m_peak);
      m_peak = pk; m_fade = 1;
      if (m_fcnt + 1 >= len) begin
        m_fcnt = 0;
        if (pk < c_low) apply(c_fstep, 2, "R3");
        else begin m_fade = 0; exp_tag = "R4"; end
      end else m_fcnt++;
    end else begin
      m_acc += c_tgt - lvl;
      m_scnt++;
      exp_tag = "R5";
      if (m_scnt >= (1 << c_log2)) begin
        mean = m_acc >>> c_log2;
        m_acc = 0; m_scnt = 0;
        if (mean > c_hyst || mean < -c_hyst) apply(mean >>> c_shift, 3, "R5");
        else exp_tag = "R6";
      end
    end
  endtask

  task automatic check_out();
    n_checks++;
    if (gain_valid !== exp_valid || int'(gain_src) != exp_src ||
        s16(int'(gain_out)) != m_gain) begin
      n_fail++;
      $display("FAIL %s: actual valid=%0b gain=%0d src=%0d expected valid=%0b gain=%0d src=%0d",
               exp_tag, gain_valid, s16(int'(gain_out)), gain_src, exp_valid, m_gain, exp_src);
    end
  endtask

  task automatic smp(input int lvl);
    @(negedge clk);
    check_out();
    cfg_we = 0;
    lvl_valid = 1;
    lvl_in = lvl[15:0];
    model_sample(lvl);
  endtask

  task automatic idle();
    @(negedge clk);
    check_out();
    cfg_we = 0;
    lvl_valid = 0;
    exp_valid = 0; exp_src = 0; exp_tag = "R10";
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    check_out();
    lvl_valid = 0;
    cfg_we = 1;
    cfg_addr = a[3:0];
    cfg_wdata = d[15:0];
    exp_valid = 0; exp_src = 0; exp_tag = "R9";
    case (a)
      0: c_up = s16(d);
      1: c_ustep = d & 16'hFFFF;
      2: c_low = s16(d);
      3: c_fstep = d & 16'hFFFF;
      4: c_flen = d & 8'hFF;
      5: c_tgt = s16(d);
      6: c_hyst = d & 16'hFFFF;
      7: c_log2 = d & 7;
      8: c_shift = d & 15;
      9: c_min = s16(d);
      10: c_max = s16(d);
      default: ;
    endcase
  endtask

  function automatic int rnd(input int lo, input int hi);
    return lo + int'($urandom_range(0, hi - lo));
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R10 watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0; lvl_valid = 0; lvl_in = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (3) @(posedge clk);
    // R1: reset state
    exp_tag = "R1";
    idle(); idle();
    // R3 / R9 defaults: four deep-fade samples give +6
    for (int i = 0; i < 4; i++) smp(-6400);
    // R2 overload with default upper step
    smp(0);
    // R9 unmapped address ignored, overload step unchanged
    wr(15, 1); wr(11, 16'h7FFF);
    smp(0);
    // R4 fade window recovering
    smp(-6400); smp(-1000); smp(-1000); smp(-1000);
    // R6 on-target and on-band-edge windows, R5 just outside
    for (int i = 0; i < 16; i++) smp(-1280);
    for (int i = 0; i < 16; i++) smp(-1280 - 128);
    for (int i = 0; i < 16; i++) smp(-1280 + 128);
    for (int i = 0; i < 16; i++) smp(-1280 - 200);
    for (int i = 0; i < 16; i++) smp(-1280 + 300);
    idle();
    // R8 clamps
    wr(10, 100); wr(4, 1); wr(3, 40);
    for (int i = 0; i < 8; i++) smp(-7000);
    wr(9, -100); wr(1, 90);
    for (int i = 0; i < 6; i++) smp(500);
    // R3 fast_len zero behaves as one
    wr(4, 0);
    for (int i = 0; i < 3; i++) smp(-7000);
    wr(9, -2048); wr(10, 2048); wr(4, 4); wr(3, 6); wr(1, 64);
    // R7 priority: overload inside fade window
    smp(-6400); smp(-6400); smp(0); smp(-6400); smp(-6400); smp(-6400); smp(-6400);
    // random mix
    for (int it = 0; it < 6000; it++) begin
      int r;
      r = rnd(0, 99);
      if (r < 8) idle();
      else if (r < 13) begin
        int a;
        a = rnd(0, 8);
        case (a)
          0: wr(5, rnd(-2200, -500));
          1: wr(6, rnd(0, 300));
          2: wr(7, rnd(0, 7));
          3: wr(8, rnd(0, 6));
          4: wr(4, rnd(0, 9));
          5: wr(3, rnd(1, 40));
          6: wr(1, rnd(1, 200));
          7: wr(9, rnd(-3000, -200));
          default: wr(10, rnd(200, 3000));
        endcase
      end else if (r < 25) smp(rnd(c_up + 1, 2000));
      else if (r < 45) smp(rnd(-8000, c_low - 1));
      else smp(rnd(c_tgt - 700, c_tgt + 700));
    end
    idle(); idle();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule